// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces display raster timing from a single pixel clock. Software programs horizontal and vertical spans (sync, back porch, active, front porch) through a small register port. The block then drives active-high sync pulses, a data-enable, a field flag and a pixel-request strobe. The request strobe leads data-enable by one clock, so an upstream pixel FIFO can present each pixel in time.

A second vertical span set serves the even field of an interlaced frame. Software normally programs its back porch one line shorter than the odd set, and programs each set's active count as half of the frame's active lines. At the first pixel of every field the block emits a one-cycle vertical-start pulse, which tells the upstream compositor to begin fetching. A sticky interrupt status is set at the start of vertical front porch when enabled, and software clears it by writing one.

Running is controlled by an enable bit, a continuous bit and an interlace bit. When enable is cleared, the current field completes before the block stops, and the enable bit then reads zero. With continuous mode off, the block runs one frame and stops by itself.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every output is low, and a read of the control register (address 0) returns 0.
- R2: Each line lasts hsync+hback+hact+hfront clocks, with hsync_o high for the first hsync clocks. Timing is set by address 1 (hback in bits 11:0, hsync in bits 27:16) and address 2 (hfront in bits 11:0, hact in bits 27:16).
- R3: Each field lasts vsync+vback+vact+vfront lines, with vsync_o high on the first vsync lines. The odd or progressive set is at address 3 (vback 11:0, vsync 27:16) and address 4 (vfront 11:0, vact 27:16).
- R4: de_o is high only for pixels hsync+hback to hsync+hback+hact-1 of lines vsync+vback to vsync+vback+vact-1.
- R5: pix_req_o is high exactly in the clock cycle before each cycle in which de_o is high.
- R6: field_o stays 0 in progressive mode. In interlaced mode (control bit 2) it toggles at each field wrap, starting at 0. Field 1 takes its vertical spans from addresses 5 and 6, which use the same field layout as addresses 3 and 4.
- R7: vstart_o pulses for one clock at the first pixel of every field.
- R8: The interrupt status (address 8, bit 0, also driven on irq_o) is set at the first pixel of the first front-porch line when address 7 bit 0 is 1. It is never set while that bit is 0. Writing 1 to the status clears it; writing 0 has no effect.
- R9: Control bit 0 starts the generator. Clearing it lets the current field finish and then stops all outputs. On read, bit 0 shows whether the generator is running, and bits 1 and 2 return the continuous and interlace bits.
- R10: With continuous (control bit 1) at 0, the generator runs one frame and then stops and clears its enable. A frame is one field in progressive mode and an odd plus an even field when interlaced.
- R11: Timing registers at addresses 1 to 6 read back the values last written into their two 12-bit fields, and reset to 1 in every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field, 0 odd or progressive, 1 even |
| pix_req_o | output | 1 | Pixel request, one clock ahead of de_o |
| vstart_o | output | 1 | Field-start pulse toward the compositor |
| irq_o | output | 1 | Sticky front-porch interrupt status |

## Verification
A horizontal or vertical counter that goes wrong shows within one clock as a sync or data-enable edge in the wrong cycle. A wrong field bit shows within one line as a shifted active region, because the even set has a different back porch, and it shows at the next wrap as a wrong field_o. Errors in run-state or stop logic show as outputs that keep toggling after a field should have ended, or as a mismatched enable readback. The bench compares every output against a behavioural raster model on every clock, so a divergence is caught in the cycle where it first appears.

// File: rtl/rtg_pkg.sv
// Shared register addresses and bit positions for the raster timing generator.
package rtg_pkg;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_HT_A   = 1;   // first of six timing registers
    localparam int ADDR_IRQ_EN = 7;
    localparam int ADDR_IRQ_ST = 8;
    localparam int NUM_TIM     = 6;
    localparam int HI_LSB      = 16;  // upper span field position
    localparam int CTL_EN      = 0;
    localparam int CTL_CONT    = 1;
    localparam int CTL_INTL    = 2;
endpackage

// File: rtl/rtg_regs.sv
// Register file: control bits, six timing registers with two spans each,
// interrupt enable and sticky write-one-to-clear status.
// Assumes CW <= 16 so each span fits its half of a data word.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          running_i,
    input  logic          auto_stop_i,
    input  logic          fp_start_i,
    output logic          en_o,
    output logic          cont_o,
    output logic          intl_o,
    output logic          irq_o,
    output logic [CW-1:0] hbp_o, hsw_o, hfp_o, hact_o,
    output logic [CW-1:0] obp_o, osw_o, ofp_o, oact_o,
    output logic [CW-1:0] ebp_o, esw_o, efp_o, eact_o
);
    logic [1:0][CW-1:0] tim_q [NUM_TIM];
    logic en_q, cont_q, intl_q, ien_q, ist_q;
    logic wr_ctrl, clr_ist;
    logic unused_bits;

    assign unused_bits = ^wr_data;
    assign wr_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
    assign clr_ist = wr_en && (wr_addr == AW'(ADDR_IRQ_ST)) && wr_data[0];

    // Timing registers, one process per register.
    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q[g] <= {CW'(1), CW'(1)};
            else if (wr_en && wr_addr == AW'(ADDR_HT_A + g)) begin
                tim_q[g][0] <= wr_data[CW-1:0];
                tim_q[g][1] <= wr_data[HI_LSB +: CW];
            end
        end
    end

    // Control bits; a software write wins over the one-frame auto stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            intl_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q   <= wr_data[CTL_EN];
            cont_q <= wr_data[CTL_CONT];
            intl_q <= wr_data[CTL_INTL];
        end else if (auto_stop_i) begin
            en_q   <= 1'b0;
        end
    end

    // Interrupt enable and sticky status; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            ist_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == AW'(ADDR_IRQ_EN))
                ien_q <= wr_data[0];
            if (fp_start_i && ien_q)
                ist_q <= 1'b1;
            else if (clr_ist)
                ist_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL)) begin
            rd_data[CTL_EN]   = running_i;
            rd_data[CTL_CONT] = cont_q;
            rd_data[CTL_INTL] = intl_q;
        end
        if (rd_addr == AW'(ADDR_IRQ_EN)) rd_data[0] = ien_q;
        if (rd_addr == AW'(ADDR_IRQ_ST)) rd_data[0] = ist_q;
        for (int i = 0; i < NUM_TIM; i++) begin
            if (rd_addr == AW'(ADDR_HT_A + i)) begin
                rd_data[CW-1:0]       = tim_q[i][0];
                rd_data[HI_LSB +: CW] = tim_q[i][1];
            end
        end
    end

    assign en_o   = en_q;
    assign cont_o = cont_q;
    assign intl_o = intl_q;
    assign irq_o  = ist_q;
    assign hbp_o  = tim_q[0][0];
    assign hsw_o  = tim_q[0][1];
    assign hfp_o  = tim_q[1][0];
    assign hact_o = tim_q[1][1];
    assign obp_o  = tim_q[2][0];
    assign osw_o  = tim_q[2][1];
    assign ofp_o  = tim_q[3][0];
    assign oact_o = tim_q[3][1];
    assign ebp_o  = tim_q[4][0];
    assign esw_o  = tim_q[4][1];
    assign efp_o  = tim_q[5][0];
    assign eact_o = tim_q[5][1];
endmodule

// File: rtl/rtg_hcount.sv
// Pixel counter within a line. Holds at zero while the generator is idle.
// Assumes every span is at least 1.
module rtg_hcount #(
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [CW-1:0]   sw_i,
    input  logic [CW-1:0]   bp_i,
    input  logic [CW-1:0]   act_i,
    input  logic [CW-1:0]   fp_i,
    output logic [CW+1:0]   pos_o,
    output logic            line_end_o
);
    localparam int SW = CW + 2;
    logic [SW-1:0] pos_q, total;

    assign total      = SW'(sw_i) + SW'(bp_i) + SW'(act_i) + SW'(fp_i);
    assign line_end_o = run_i && (pos_q == total - SW'(1));
    assign pos_o      = pos_q;

    // Advance one pixel per clock and wrap at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            pos_q <= '0;
        else if (line_end_o)
            pos_q <= '0;
        else
            pos_q <= pos_q + SW'(1);
    end
endmodule

// File: rtl/rtg_vcount.sv
// Line counter, field flag and run state. Chooses the odd or even vertical
// set, and stops at a field end when disabled or when a single frame is done.
module rtg_vcount #(
    parameter int CW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            cont_i,
    input  logic            intl_i,
    input  logic            line_end_i,
    input  logic [CW-1:0]   obp_i, osw_i, ofp_i, oact_i,
    input  logic [CW-1:0]   ebp_i, esw_i, efp_i, eact_i,
    output logic [CW-1:0]   bp_o, sw_o, act_o,
    output logic [CW+1:0]   pos_o,
    output logic            field_o,
    output logic            running_o,
    output logic            auto_stop_o
);
    localparam int SW = CW + 2;
    logic [SW-1:0] pos_q, total;
    logic          field_q, run_q, use_even, field_end, last_field, stop_now;
    logic [CW-1:0] fp_sel;

    assign use_even = intl_i && field_q;
    assign bp_o     = use_even ? ebp_i  : obp_i;
    assign sw_o     = use_even ? esw_i  : osw_i;
    assign act_o    = use_even ? eact_i : oact_i;
    assign fp_sel   = use_even ? efp_i  : ofp_i;
    assign total    = SW'(sw_o) + SW'(bp_o) + SW'(act_o) + SW'(fp_sel);

    assign field_end   = line_end_i && (pos_q == total - SW'(1));
    assign last_field  = !intl_i || field_q;
    assign stop_now    = field_end && (!en_i || (!cont_i && last_field));
    assign auto_stop_o = field_end && en_i && !cont_i && last_field;

    // Run state, line count and field flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            pos_q   <= '0;
            field_q <= 1'b0;
        end else if (!run_q) begin
            run_q   <= en_i;
            pos_q   <= '0;
            field_q <= 1'b0;
        end else if (stop_now) begin
            run_q   <= 1'b0;
            pos_q   <= '0;
            field_q <= 1'b0;
        end else if (field_end) begin
            pos_q   <= '0;
            field_q <= intl_i ? !field_q : 1'b0;
        end else if (line_end_i) begin
            pos_q   <= pos_q + SW'(1);
        end
    end

    assign pos_o     = pos_q;
    assign field_o   = field_q;
    assign running_o = run_q;
endmodule

// File: rtl/raster_timing_gen.sv
// Top level: register port, pixel and line counters, and the raster decode.
// Sync, data-enable, field and vstart outputs are registered, so they
// follow the counter state by one clock. pix_req_o is decoded from the
// same state without a register, so it leads de_o by one clock.
module raster_timing_gen #(
    parameter int CW = 12,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          field_o,
    output logic          pix_req_o,
    output logic          vstart_o,
    output logic          irq_o
);
    localparam int SW = CW + 2;

    logic          en, cont, intl, running, auto_stop, line_end, field;
    logic [CW-1:0] hbp, hsw, hfp, hact, obp, osw, ofp, oact, ebp, esw, efp, eact;
    logic [CW-1:0] vbp, vsw, vact;
    logic [SW-1:0] hpos, vpos, h_act_lo, h_act_hi, v_act_lo, v_act_hi;
    logic          hs_c, vs_c, de_c, vst_c, fp_start;

    rtg_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .running_i(running), .auto_stop_i(auto_stop), .fp_start_i(fp_start),
        .en_o(en), .cont_o(cont), .intl_o(intl), .irq_o(irq_o),
        .hbp_o(hbp), .hsw_o(hsw), .hfp_o(hfp), .hact_o(hact),
        .obp_o(obp), .osw_o(osw), .ofp_o(ofp), .oact_o(oact),
        .ebp_o(ebp), .esw_o(esw), .efp_o(efp), .eact_o(eact)
    );

    rtg_hcount #(.CW(CW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .run_i(running),
        .sw_i(hsw), .bp_i(hbp), .act_i(hact), .fp_i(hfp),
        .pos_o(hpos), .line_end_o(line_end)
    );

    rtg_vcount #(.CW(CW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cont_i(cont), .intl_i(intl),
        .line_end_i(line_end),
        .obp_i(obp), .osw_i(osw), .ofp_i(ofp), .oact_i(oact),
        .ebp_i(ebp), .esw_i(esw), .efp_i(efp), .eact_i(eact),
        .bp_o(vbp), .sw_o(vsw), .act_o(vact),
        .pos_o(vpos), .field_o(field), .running_o(running),
        .auto_stop_o(auto_stop)
    );

    assign h_act_lo = SW'(hsw) + SW'(hbp);
    assign h_act_hi = h_act_lo + SW'(hact);
    assign v_act_lo = SW'(vsw) + SW'(vbp);
    assign v_act_hi = v_act_lo + SW'(vact);

    assign hs_c     = running && (hpos < SW'(hsw));
    assign vs_c     = running && (vpos < SW'(vsw));
    assign de_c     = running && (hpos >= h_act_lo) && (hpos < h_act_hi)
                              && (vpos >= v_act_lo) && (vpos < v_act_hi);
    assign vst_c    = running && (hpos == '0) && (vpos == '0);
    assign fp_start = running && (hpos == '0) && (vpos == v_act_hi);
    assign pix_req_o = de_c;

    // Register the raster outputs from the current counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o  <= 1'b0;
            vsync_o  <= 1'b0;
            de_o     <= 1'b0;
            field_o  <= 1'b0;
            vstart_o <= 1'b0;
        end else begin
            hsync_o  <= hs_c;
            vsync_o  <= vs_c;
            de_o     <= de_c;
            field_o  <= field;
            vstart_o <= vst_c;
        end
    end
endmodule

// File: rtl/rtg_checker.sv
// Temporal properties of the raster timing generator, bound into the top.
module rtg_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          wr_bit0,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic          pix_req,
    input logic          vstart,
    input logic          irq,
    input logic          running
);
    logic clr_w;
    assign clr_w = wr_en && (wr_addr == AW'(8)) && wr_bit0;

    // R4: data-enable never overlaps a sync pulse
    p_de_outside_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

    // R5: every request is followed by data-enable
    p_req_then_de_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> de);

    // R5: every data-enable was requested one cycle earlier
    p_de_was_requested_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> $past(pix_req));

    // R7: field start is a single-cycle pulse
    p_vstart_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vstart |=> !vstart);

    // R8: status stays set unless cleared by a write of one
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq);

    // R9: once stopped, no active video is emitted
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!de && !hsync && !vsync));
endmodule

bind raster_timing_gen rtg_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit0(wr_data[0]), .hsync(hsync_o), .vsync(vsync_o), .de(de_o),
    .pix_req(pix_req_o), .vstart(vstart_o), .irq(irq_o), .running(running)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic hsync_o, vsync_o, de_o, field_o, pix_req_o, vstart_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural model state
    int h, v, f, run, enq, cont, intl, ien, ist;
    int tm [6][2];
    bit e_hs, e_vs, e_de, e_fld, e_vst;
    int hs, hb, ha, hf, vs, vb, va, vf, sel, htot, vtot;
    bit fp, clr, lend, fend, lastf, stop, astop;

    always #2 clk = ~clk;

    raster_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
        .pix_req_o(pix_req_o), .vstart_o(vstart_o), .irq_o(irq_o)
    );

    task automatic chk1(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Load the active vertical set and spans from the model registers.
    task automatic spans();
        sel = (intl != 0 && f != 0) ? 1 : 0;
        hb = tm[0][0]; hs = tm[0][1]; hf = tm[1][0]; ha = tm[1][1];
        vb = tm[2 + 2*sel][0]; vs = tm[2 + 2*sel][1];
        vf = tm[3 + 2*sel][0]; va = tm[3 + 2*sel][1];
        htot = hs + hb + ha + hf;
        vtot = vs + vb + va + vf;
    endtask

    function automatic bit de_at();
        return run != 0 && h >= hs + hb && h < hs + hb + ha
                        && v >= vs + vb && v < vs + vb + va;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            h = 0; v = 0; f = 0; run = 0; enq = 0; cont = 0; intl = 0; ien = 0; ist = 0;
            for (int i = 0; i < 6; i++) begin tm[i][0] = 1; tm[i][1] = 1; end
            e_hs = 0; e_vs = 0; e_de = 0; e_fld = 0; e_vst = 0;
        end else begin
            spans();
            e_hs  = run != 0 && h < hs;
            e_vs  = run != 0 && v < vs;
            e_de  = de_at();
            e_fld = f != 0;
            e_vst = run != 0 && h == 0 && v == 0;
            fp  = run != 0 && h == 0 && v == vs + vb + va;
            clr = wr_en && wr_addr == 8 && wr_data[0];
            if (fp && ien != 0) ist = 1;
            else if (clr) ist = 0;
            if (run == 0) begin
                if (enq != 0) run = 1;
                h = 0; v = 0; f = 0;
            end else begin
                lend  = h == htot - 1;
                fend  = lend && v == vtot - 1;
                lastf = intl == 0 || f != 0;
                stop  = fend && (enq == 0 || (cont == 0 && lastf));
                astop = fend && enq != 0 && cont == 0 && lastf;
                if (stop) begin
                    run = 0; h = 0; v = 0; f = 0;
                end else begin
                    h = lend ? 0 : h + 1;
                    if (fend) begin v = 0; f = intl != 0 ? 1 - f : 0; end
                    else if (lend) v = v + 1;
                end
                if (astop) enq = 0;
            end
            if (wr_en) begin
                if (wr_addr == 0) begin
                    enq = wr_data[0]; cont = wr_data[1]; intl = wr_data[2];
                end else if (wr_addr >= 1 && wr_addr <= 6) begin
                    tm[wr_addr-1][0] = wr_data[11:0];
                    tm[wr_addr-1][1] = wr_data[27:16];
                end else if (wr_addr == 7) begin
                    ien = wr_data[0];
                end
            end
        end
        if (cyc > 200000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk1(hsync_o,  e_hs,  "R2 hsync");
            chk1(vsync_o,  e_vs,  "R3 vsync");
            chk1(de_o,     e_de,  "R4 de");
            chk1(field_o,  e_fld, "R6 field");
            chk1(vstart_o, e_vst, "R7 vstart");
            chk1(irq_o,    ist != 0, "R8 irq");
            spans();
            chk1(pix_req_o, de_at(), "R5 pix_req");
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = 4'(a);
        #1;
        chk32(rd_data, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(0, 32'h0, "R1 ctrl after reset");
        chk1(hsync_o | vsync_o | de_o | field_o | pix_req_o | vstart_o | irq_o, 1'b0, "R1 outputs low");
        // R11: reset values and readback
        rd_chk(3, 32'h0001_0001, "R11 reset value");
        wr(1, (2 << 16) | 3);
        wr(2, (4 << 16) | 2);
        wr(3, (1 << 16) | 2);
        wr(4, (3 << 16) | 1);
        wr(5, (1 << 16) | 1);
        wr(6, (3 << 16) | 1);
        rd_chk(1, 32'h0002_0003, "R11 readback h back/sync");
        rd_chk(6, 32'h0003_0001, "R11 readback even front/active");
        // R8: enabled interrupt, progressive continuous run
        wr(7, 1);
        wr(0, 3);
        idle(200);
        rd_chk(0, 32'h3, "R9 running readback");
        chk1(irq_o, 1'b1, "R8 status set at front porch");
        wr(8, 0);
        chk1(irq_o, 1'b1, "R8 write zero keeps status");
        wr(8, 1);
        idle(100);
        // R6: interlaced continuous run across several fields
        wr(0, 7);
        idle(400);
        rd_chk(0, 32'h7, "R9 interlaced running readback");
        // R9: disable finishes the field then stops
        wr(0, 0);
        idle(200);
        rd_chk(0, 32'h0, "R9 stopped readback");
        chk1(de_o | hsync_o | vsync_o, 1'b0, "R9 outputs quiet after stop");
        // R10: single progressive frame
        wr(0, 1);
        idle(150);
        rd_chk(0, 32'h0, "R10 single progressive frame stopped");
        // R10: single interlaced frame
        wr(0, 5);
        idle(200);
        rd_chk(0, 32'h4, "R10 single interlaced frame stopped");
        // R8: disabled interrupt is never set
        wr(7, 0);
        wr(8, 1);
        wr(0, 3);
        idle(160);
        chk1(irq_o, 1'b0, "R8 status stays clear when disabled");
        rd_chk(8, 32'h0, "R8 status readback clear");
        wr(0, 0);
        idle(100);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule